// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of a serial EEPROM with 32K x 8 storage. It watches the two-wire serial clock and data lines, which arrive oversampled on the system clock. It recognises bus start and stop conditions and checks the addressing byte against a fixed device class and three strap pins. For writes it collects a two-byte word address and then data bytes. For reads it shifts stored bytes out MSB first. It never drives the data line high. It only requests an open-drain pull-down through `dat_pull_o`.

The engine does not hold the storage array or the address counter. Instead it emits single-cycle strobes to the neighbouring logic:
- a word-address load with the 15-bit address;
- a data-byte load with the received byte;
- a read fetch, after which the counter logic returns the addressed byte on `rd_byte_i` one cycle later;
- a commit request that starts the internal program cycle.

A write-lock input suppresses data acceptance. A busy input from the program-cycle controller makes the engine deaf to its own address, so a master can poll until programming completes.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset `dat_pull_o` is 0 and no strobe output (`rd_stb_o`, `wa_stb_o`, `wd_stb_o`, `commit_o`) is asserted.
- R2: The first byte after a start is taken MSB first. It is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_strap_i`; bit 0 selects read (1) or write (0). On a mismatch the engine does not acknowledge and ignores the bus until the next start.
- R3: After a write-direction addressing byte, two address bytes follow, high byte first. A single `wa_stb_o` pulse then carries `wa_o` = {high[6:0], low}; bit 7 of the high byte is ignored.
- R4: Every accepted byte is acknowledged by holding `dat_pull_o` high through the 9th bus clock, released after that clock falls. Each accepted write data byte gives one `wd_stb_o` pulse with the byte on `wd_o`.
- R5: A stop gives exactly one `commit_o` pulse when at least one data byte was accepted since the last start; a stop after address bytes only gives none.
- R6: With `wr_lock_i` high, the addressing and both address bytes are acknowledged, the first data byte is not, no `wd_stb_o` is issued and the following stop gives no commit.
- R7: A repeated start after the address bytes, followed by a read-direction addressing byte, reads from the loaded address. Each byte is preceded by one `rd_stb_o`, and the returned byte is shifted out MSB first. The master's acknowledge requests the next byte.
- R8: When the master does not acknowledge a read byte, the engine releases the line, issues no further `rd_stb_o` and drives nothing until the next start.
- R9: While `cyc_busy_i` is high, a matching addressing byte is not acknowledged.
- R10: A start seen in any state restarts addressing, including in the middle of a byte. It discards accepted data bytes, so a later stop gives no commit.
- R11: `dat_pull_o` changes only while the synchronised bus clock is low, except when a start or stop resets it.
- R12: A read-direction addressing byte without address bytes reads from the current counter position: `rd_stb_o` is issued with no `wa_stb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bus clock line (raw) |
| bus_dat_i | input | 1 | Serial bus data line as seen on the wire (raw) |
| sel_strap_i | input | 3 | Strap pins compared with addressing bits 3:1 |
| wr_lock_i | input | 1 | Write lock, refuses data bytes when high |
| cyc_busy_i | input | 1 | Program cycle in progress |
| rd_byte_i | input | 8 | Byte returned one cycle after a fetch strobe |
| dat_pull_o | output | 1 | Pull data line low (open-drain enable) |
| rd_stb_o | output | 1 | Fetch next byte and advance counter |
| wa_stb_o | output | 1 | Load word address into counter |
| wa_o | output | 15 | Word address value |
| wd_stb_o | output | 1 | Load received data byte |
| wd_o | output | 8 | Received data byte |
| commit_o | output | 1 | Start internal program cycle |

## Verification
The assertions assume a well-behaved master. It changes the data line only while the bus clock is low, apart from start and stop. Each bus clock phase lasts longer than the synchroniser delay plus the fetch latency, and `rd_byte_i` is valid in the cycle after the fetch strobe is registered. The bench keeps within this by holding each bus clock half period for 16 system cycles and moving data 4 cycles after each falling edge. It toggles `wr_lock_i` and `cyc_busy_i` only while the bus is idle.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 3;
    localparam logic [3:0]  DEV_CLASS = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } eng_state_e;

    typedef enum logic [1:0] {
        BR_DEV,
        BR_AHI,
        BR_ALO,
        BR_DATA
    } byte_role_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LINES  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= chain_d;
        end

        assign lvl_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/eep_bus_events.sv
module eep_bus_events (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic clk;
        logic dat;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.clk = scl_i;
        prev_d.dat = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '{clk: 1'b1, dat: 1'b1};
        else         prev_q <= prev_d;
    end

    assign scl_rise_o = scl_i & ~prev_q.clk;
    assign scl_fall_o = ~scl_i & prev_q.clk;
    assign start_o    = scl_i & prev_q.clk & prev_q.dat & ~sda_i;
    assign stop_o     = scl_i & prev_q.clk & ~prev_q.dat & sda_i;
endmodule

// File: rtl/eep_slave_fsm.sv
module eep_slave_fsm
    import eep_slave_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [SEL_W-1:0]  strap_i,
    input  logic              lock_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              pull_o,
    output logic              rd_stb_o,
    output logic              wa_stb_o,
    output logic [ADDR_W-1:0] wa_o,
    output logic              wd_stb_o,
    output logic [BYTE_W-1:0] wd_o,
    output logic              commit_o
);
    localparam int unsigned HI_W  = ADDR_W - BYTE_W;
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        eng_state_e        st;
        byte_role_e        role;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic [HI_W-1:0]   ahi;
        logic              pend;
        logic [1:0]        fetch;
        logic              mack;
        logic              pull;
        logic              rd_stb;
        logic              wa_stb;
        logic              wd_stb;
        logic              cm_stb;
        logic [ADDR_W-1:0] wa;
        logic [BYTE_W-1:0] wd;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d        = eng_q;
        eng_d.rd_stb = 1'b0;
        eng_d.wa_stb = 1'b0;
        eng_d.wd_stb = 1'b0;
        eng_d.cm_stb = 1'b0;

        if (start_i) begin
            eng_d.st    = ST_RX;
            eng_d.role  = BR_DEV;
            eng_d.cnt   = '0;
            eng_d.pull  = 1'b0;
            eng_d.pend  = 1'b0;
            eng_d.fetch = 2'd0;
        end else if (stop_i) begin
            eng_d.st     = ST_IDLE;
            eng_d.pull   = 1'b0;
            eng_d.cm_stb = eng_q.pend;
            eng_d.pend   = 1'b0;
            eng_d.fetch  = 2'd0;
        end else begin
            case (eng_q.st)
                ST_RX: begin
                    if (scl_rise_i && (eng_q.cnt < FULL_CNT)) begin
                        eng_d.sh  = {eng_q.sh[BYTE_W-2:0], sda_lvl_i};
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end else if (scl_fall_i && (eng_q.cnt == FULL_CNT)) begin
                        eng_d.cnt  = '0;
                        eng_d.st   = ST_ACK;
                        eng_d.pull = 1'b1;
                        case (eng_q.role)
                            BR_DEV: begin
                                if ((eng_q.sh[7:4] == DEV_CLASS) &&
                                    (eng_q.sh[3:1] == strap_i) && !busy_i) begin
                                    eng_d.rw = eng_q.sh[0];
                                end else begin
                                    eng_d.st   = ST_SKIP;
                                    eng_d.pull = 1'b0;
                                end
                            end
                            BR_AHI: eng_d.ahi = eng_q.sh[HI_W-1:0];
                            BR_ALO: begin
                                eng_d.wa_stb = 1'b1;
                                eng_d.wa     = {eng_q.ahi, eng_q.sh};
                            end
                            default: begin
                                if (!lock_i) begin
                                    eng_d.wd_stb = 1'b1;
                                    eng_d.wd     = eng_q.sh;
                                    eng_d.pend   = 1'b1;
                                end else begin
                                    eng_d.st   = ST_SKIP;
                                    eng_d.pull = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        eng_d.pull = 1'b0;
                        eng_d.st   = ST_RX;
                        case (eng_q.role)
                            BR_DEV: begin
                                if (eng_q.rw) begin
                                    eng_d.st     = ST_TX;
                                    eng_d.rd_stb = 1'b1;
                                    eng_d.fetch  = 2'd2;
                                end else begin
                                    eng_d.role = BR_AHI;
                                end
                            end
                            BR_AHI:  eng_d.role = BR_ALO;
                            default: eng_d.role = BR_DATA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (eng_q.fetch == 2'd2) begin
                        eng_d.fetch = 2'd1;
                    end else if (eng_q.fetch == 2'd1) begin
                        eng_d.fetch = 2'd0;
                        eng_d.sh    = rd_byte_i;
                        eng_d.pull  = ~rd_byte_i[BYTE_W-1];
                        eng_d.cnt   = '0;
                    end else if (scl_fall_i) begin
                        if (eng_q.cnt == LAST_TX) begin
                            eng_d.st   = ST_MACK;
                            eng_d.pull = 1'b0;
                        end else begin
                            eng_d.sh   = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            eng_d.pull = ~eng_q.sh[BYTE_W-2];
                            eng_d.cnt  = eng_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        eng_d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (eng_q.mack) begin
                            eng_d.st     = ST_TX;
                            eng_d.rd_stb = 1'b1;
                            eng_d.fetch  = 2'd2;
                        end else begin
                            eng_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.role <= BR_DEV;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign pull_o   = eng_q.pull;
    assign rd_stb_o = eng_q.rd_stb;
    assign wa_stb_o = eng_q.wa_stb;
    assign wa_o     = eng_q.wa;
    assign wd_stb_o = eng_q.wd_stb;
    assign wd_o     = eng_q.wd;
    assign commit_o = eng_q.cm_stb;

    // R11: the line pull moves only while the bus clock is low, or on start/stop
    p_pull_clk_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(eng_q.pull) |-> (!$past(scl_lvl_i) || $past(start_i) || $past(stop_i)));

    // R5: a commit request follows a stop condition
    p_commit_at_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_q.cm_stb |-> $past(stop_i));

    // R6: no data load while write lock was high
    p_lock_blocks_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_q.wd_stb |-> !$past(lock_i));

    // R4: at most one strobe per cycle
    p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({eng_q.rd_stb, eng_q.wa_stb, eng_q.wd_stb, eng_q.cm_stb}));

    // R9: addressing acknowledge never given while busy
    p_busy_no_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_ACK && eng_q.role == BR_DEV && $past(eng_q.st) == ST_RX)
        |-> !$past(busy_i));

    // R7: a fetch is only requested right after a bus clock falling edge
    p_fetch_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_q.rd_stb |-> $past(scl_fall_i));
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave
    import eep_slave_pkg::*;
#(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    input  logic [2:0]        sel_strap_i,
    input  logic              wr_lock_i,
    input  logic              cyc_busy_i,
    input  logic [7:0]        rd_byte_i,
    output logic              dat_pull_o,
    output logic              rd_stb_o,
    output logic              wa_stb_o,
    output logic [ADDR_W-1:0] wa_o,
    output logic              wd_stb_o,
    output logic [7:0]        wd_o,
    output logic              commit_o
);
    logic [1:0] lvl;
    logic       scl_rise, scl_fall, cond_start, cond_stop;

    eep_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({bus_dat_i, bus_clk_i}),
        .lvl_o  (lvl)
    );

    eep_bus_events u_events (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (lvl[0]),
        .sda_i      (lvl[1]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (cond_start),
        .stop_o     (cond_stop)
    );

    eep_slave_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_lvl_i  (lvl[0]),
        .sda_lvl_i  (lvl[1]),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (cond_start),
        .stop_i     (cond_stop),
        .strap_i    (sel_strap_i),
        .lock_i     (wr_lock_i),
        .busy_i     (cyc_busy_i),
        .rd_byte_i  (rd_byte_i),
        .pull_o     (dat_pull_o),
        .rd_stb_o   (rd_stb_o),
        .wa_stb_o   (wa_stb_o),
        .wa_o       (wa_o),
        .wd_stb_o   (wd_stb_o),
        .wd_o       (wd_o),
        .commit_o   (commit_o)
    );

    // R1: nothing is driven or strobed in the first cycle after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!dat_pull_o && !rd_stb_o && !wa_stb_o && !wd_stb_o && !commit_o));
endmodule

// File: tb/eep_serial_slave_bench.sv
`timescale 1ns/1ps
module eep_serial_slave_bench;
    localparam int H = 16;
    localparam logic [2:0] STRAP = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_clk = 1'b1;
    logic        m_dat = 1'b1;
    logic        lock = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  rd_q;
    logic        pull, rd_stb, wa_stb, wd_stb, commit;
    logic [14:0] wa;
    logic [7:0]  wd;
    logic        bus_line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int n_rd = 0, n_wa = 0, n_wd = 0, n_cm = 0;
    logic [14:0] last_wa = '0;
    logic [7:0]  last_wd = '0;
    logic [14:0] ctr = '0;
    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    logic [7:0]  stg_a [64];
    logic [7:0]  stg_d [64];
    int          stg_n = 0;
    bit          saw_pull = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_line = m_dat & ~pull;

    eep_serial_slave u_eep_serial_slave (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_clk_i   (m_clk),
        .bus_dat_i   (bus_line),
        .sel_strap_i (STRAP),
        .wr_lock_i   (lock),
        .cyc_busy_i  (busy),
        .rd_byte_i   (rd_q),
        .dat_pull_o  (pull),
        .rd_stb_o    (rd_stb),
        .wa_stb_o    (wa_stb),
        .wa_o        (wa),
        .wd_stb_o    (wd_stb),
        .wd_o        (wd),
        .commit_o    (commit)
    );

    function automatic logic [7:0] seed_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // counter and storage model on the strobe side
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
            rd_q <= '0;
            ctr  <= '0;
        end else begin
            if (rd_stb) begin
                rd_q <= mem[ctr[7:0]];
                ctr  <= ctr + 15'd1;
                n_rd <= n_rd + 1;
            end
            if (wa_stb) begin
                ctr     <= wa;
                last_wa <= wa;
                n_wa    <= n_wa + 1;
            end
            if (wd_stb) begin
                stg_a[stg_n[5:0]] <= ctr[7:0];
                stg_d[stg_n[5:0]] <= wd;
                stg_n   <= stg_n + 1;
                ctr     <= {ctr[14:6], ctr[5:0] + 6'd1};
                last_wd <= wd;
                n_wd    <= n_wd + 1;
            end
            if (commit) begin
                for (int i = 0; i < 64; i++)
                    if (i < stg_n) mem[stg_a[i]] <= stg_d[i];
                stg_n <= 0;
                n_cm  <= n_cm + 1;
            end
        end
    end

    always @(negedge clk) if (pull) saw_pull <= 1'b1;

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_fall();
        m_clk = 1'b0;
        wait_n(4);
    endtask

    task automatic bus_start();
        m_dat = 1'b1; wait_n(H);
        m_clk = 1'b1; wait_n(H);
        m_dat = 1'b0; wait_n(H);
        clk_fall();
    endtask

    task automatic bus_stop();
        m_dat = 1'b0; wait_n(H);
        m_clk = 1'b1; wait_n(H);
        m_dat = 1'b1; wait_n(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_dat = b[i]; wait_n(H);
            m_clk = 1'b1; wait_n(H);
            clk_fall();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_dat = 1'b1; wait_n(H);
        m_clk = 1'b1; wait_n(H / 2);
        ack = !bus_line;
        wait_n(H / 2);
        clk_fall();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            wait_n(H);
            m_clk = 1'b1; wait_n(H / 2);
            b[i] = bus_line;
            wait_n(H / 2);
            clk_fall();
        end
        m_dat = !give_ack; wait_n(H);
        m_clk = 1'b1; wait_n(H);
        clk_fall();
        m_dat = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic [3:0] cls, input logic [2:0] sel,
                                            input logic rw);
        return {cls, sel, rw};
    endfunction

    initial begin
        bit          ak;
        logic [7:0]  rb;
        int          c0, w0, d0, r0;
        logic [7:0]  pat [4];
        logic [15:0] base;
        pat[0] = 8'hA5; pat[1] = 8'h5A; pat[2] = 8'hC3; pat[3] = 8'h3C;
        for (int i = 0; i < 256; i++) exp_mem[i] = seed_val(i);

        wait_n(5);
        // R1: reset state
        chk("R1 pull in reset", int'(pull), 0);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 pull after reset", int'(pull), 0);
        chk("R1 strobes after reset", int'(rd_stb | wa_stb | wd_stb | commit), 0);
        wait_n(10);

        // R2: sweep of strap selections and device class values
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte(dev_byte(4'b1010, 3'(s), 1'b0), ak);
            bus_stop();
            chk($sformatf("R2 sel=%0d ack", s), int'(ak), int'(3'(s) == STRAP));
        end
        for (int c = 0; c < 16; c++) begin
            if (c == 10) continue;
            bus_start();
            send_byte(dev_byte(4'(c), STRAP, 1'b0), ak);
            bus_stop();
            chk($sformatf("R2 class=%0d ack", c), int'(ak), 0);
        end

        // R3 R4 R5: page write with top address bit set
        base = 16'h123E;
        c0 = n_cm; w0 = n_wa; d0 = n_wd;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak); chk("R4 dev ack", int'(ak), 1);
        send_byte(8'h80 | base[15:8], ak);              chk("R4 hi ack", int'(ak), 1);
        send_byte(base[7:0], ak);                       chk("R4 lo ack", int'(ak), 1);
        chk("R3 one address load", n_wa - w0, 1);
        chk("R3 address value", int'(last_wa), int'(base[14:0]));
        for (int k = 0; k < 4; k++) begin
            send_byte(pat[k], ak);
            chk($sformatf("R4 data %0d ack", k), int'(ak), 1);
            chk($sformatf("R4 data %0d value", k), int'(last_wd), int'(pat[k]));
            exp_mem[8'((base & 16'hFFC0) | ((base + 16'(k)) & 16'h003F))] = pat[k];
        end
        chk("R4 data loads", n_wd - d0, 4);
        chk("R5 no commit before stop", n_cm - c0, 0);
        bus_stop();
        wait_n(4);
        chk("R5 commit at stop", n_cm - c0, 1);

        // R5: address-only transfer gives no commit
        c0 = n_cm;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        send_byte(8'h00, ak);
        send_byte(8'h10, ak);
        bus_stop(); wait_n(4);
        chk("R5 dummy write no commit", n_cm - c0, 0);

        // R6: write lock
        lock = 1'b1;
        c0 = n_cm; d0 = n_wd;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak); chk("R6 dev ack", int'(ak), 1);
        send_byte(8'h00, ak);                          chk("R6 hi ack", int'(ak), 1);
        send_byte(8'h20, ak);                          chk("R6 lo ack", int'(ak), 1);
        send_byte(8'hEE, ak);                          chk("R6 data nack", int'(ak), 0);
        bus_stop(); wait_n(4);
        chk("R6 no data load", n_wd - d0, 0);
        chk("R6 no commit", n_cm - c0, 0);
        lock = 1'b0;

        // R7: random read of four bytes from base
        r0 = n_rd;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        send_byte(base[15:8], ak);
        send_byte(base[7:0], ak);
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b1), ak); chk("R7 read dev ack", int'(ak), 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(rb, k != 3);
            chk($sformatf("R7 read byte %0d", k), int'(rb), int'(exp_mem[8'(base[7:0] + 8'(k))]));
        end
        chk("R7 fetch count", n_rd - r0, 4);

        // R8: after no-acknowledge the line stays released
        r0 = n_rd;
        saw_pull = 1'b0;
        send_byte(8'hFF, ak);
        chk("R8 no drive after nack", int'(saw_pull), 0);
        chk("R8 no further fetch", n_rd - r0, 0);
        bus_stop();

        // R12: current address read continues from the counter
        w0 = n_wa; r0 = n_rd;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b1), ak); chk("R12 dev ack", int'(ak), 1);
        recv_byte(rb, 1'b0);
        bus_stop();
        chk("R12 byte value", int'(rb), int'(exp_mem[8'(base[7:0] + 8'd4)]));
        chk("R12 no address load", n_wa - w0, 0);
        chk("R12 one fetch", n_rd - r0, 1);

        // R9: busy polling
        busy = 1'b1;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        bus_stop();
        chk("R9 busy nack", int'(ak), 0);
        busy = 1'b0;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        bus_stop();
        chk("R9 idle ack", int'(ak), 1);

        // R10: start mid-byte restarts; start after data discards it
        c0 = n_cm;
        bus_start();
        send_bits(8'hB0, 4);
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak); chk("R10 restart ack", int'(ak), 1);
        send_byte(8'h01, ak);
        send_byte(8'h10, ak);
        send_byte(8'h77, ak);                          chk("R10 data ack", int'(ak), 1);
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        bus_stop(); wait_n(4);
        chk("R10 discarded data no commit", n_cm - c0, 0);

        // R5 R4: committed page wrap read back at page start
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), ak);
        send_byte(8'h12, ak);
        send_byte(8'h00, ak);
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b1), ak);
        recv_byte(rb, 1'b0);
        bus_stop();
        chk("R5 committed wrapped byte", int'(rb), int'(exp_mem[8'h00]));
        chk("R5 expected is pattern", int'(exp_mem[8'h00]), int'(pat[2]));

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule